// File: doc/BRIEF.md
# Three-Way Fixed-Priority Request Arbiter

This block gives one of three requesters sole use of a shared resource. Each requester raises its request line and waits for its grant line. Once a requester holds the grant, it keeps it for as long as its request stays high. A request from a higher-priority requester does not take the grant away. When the requester lowers its request, the arbiter goes back to idle for one cycle and then picks again.

The arbiter applies priority only when it picks from idle, and requester 1 wins over requester 2, which wins over requester 3. All grant lines are driven straight from the state register, so there is no combinational path from a request input to a grant output. The reset is asynchronous and active low, and it clears every grant at once.

Top module: `arb3_fixed_prio`

## Requirements
- R1: While rst_ni is low, gnt_o is 3'b000 at once, without a clock edge. After reset the arbiter is idle.
- R2: At most one bit of gnt_o is high in any cycle.
- R3: When the arbiter is idle and req_i[0] (requester 1) is high at a rising edge, gnt_o becomes 3'b001 after that edge, whatever req_i[2:1] are.
- R4: When the arbiter is idle and req_i[0] is low at a rising edge, req_i[1] high gives gnt_o = 3'b010. If req_i is 3'b100, gnt_o becomes 3'b100 instead.
- R5: When the arbiter is idle and req_i is 3'b000 at a rising edge, gnt_o stays 3'b000.
- R6: While gnt_o[k] is high and req_i[k] is high at a rising edge, gnt_o stays unchanged after that edge, whatever the other request bits are.
- R7: When gnt_o[k] is high and req_i[k] is low at a rising edge, gnt_o becomes 3'b000 after that edge. The next grant can appear one edge later at the earliest.
- R8: gnt_o changes only at a rising edge of clk_i or on reset. A change of req_i between edges leaves gnt_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state advances on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Request lines; bit 0 is requester 1 (highest priority) |
| gnt_o | output | 3 | One-hot grant lines; bit k answers req_i[k] |

## Verification
Every reachable state (idle and the three grant states) is combined with all eight request patterns. From idle, this separates the three priority choices and the stay-idle case. From a grant state, it separates holding from releasing, and it shows that the other request bits have no effect while a grant is held. After each release the same pattern is applied again, to confirm one idle cycle followed by the lowest-numbered pick. Two more tests check the grant outputs: the request lines are moved between edges, and reset is asserted in the middle of a cycle while a grant is held. Neither may change the grants in any way other than R1 and R8 allow.

// File: rtl/arb3_pkg.sv
package arb3_pkg;
  localparam int NUM_REQ = 3;
  localparam int STATE_W = NUM_REQ + 1;
  typedef logic [STATE_W-1:0] state_t;
  typedef logic [NUM_REQ-1:0] req_t;
  // bit 0 marks idle, bit k+1 marks "requester k holds grant"
  localparam state_t ST_IDLE = state_t'(1);
endpackage

// File: rtl/arb3_pick.sv
module arb3_pick
  import arb3_pkg::*;
(
  input  req_t req_i,
  output req_t win_o
);
  logic [NUM_REQ:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_pick
    assign seen[i+1] = seen[i] | req_i[i];
    assign win_o[i]  = req_i[i] & ~seen[i];
  end
endmodule

// File: rtl/arb3_next.sv
module arb3_next
  import arb3_pkg::*;
(
  input  state_t state_i,
  input  req_t   req_i,
  input  req_t   win_i,
  output state_t state_o
);
  logic legal, hold;

  always_comb begin
    legal = $onehot(state_i);
    hold  = |(state_i[STATE_W-1:1] & req_i);
    if (!legal) begin
      state_o = ST_IDLE; // recover from corrupted encoding
    end else if (state_i[0]) begin
      state_o = (|req_i) ? {win_i, 1'b0} : ST_IDLE;
    end else begin
      state_o = hold ? state_i : ST_IDLE;
    end
  end
endmodule

// File: rtl/arb3_state_reg.sv
module arb3_state_reg
  import arb3_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  state_t d_i,
  output state_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= ST_IDLE;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/arb3_fixed_prio.sv
module arb3_fixed_prio
  import arb3_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] req_i,
  output logic [2:0] gnt_o
);
  state_t state_q, state_d;
  req_t   win;

  arb3_pick i_pick (
    .req_i (req_i),
    .win_o (win)
  );

  arb3_next i_next (
    .state_i (state_q),
    .req_i   (req_i),
    .win_i   (win),
    .state_o (state_d)
  );

  arb3_state_reg i_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  assign gnt_o = state_q[STATE_W-1:1];
endmodule

// File: rtl/arb3_fixed_prio_chk.sv
module arb3_fixed_prio_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] req_i,
  input logic [2:0] gnt_o
);
  logic [2:0] low_req;
  always_comb low_req = req_i & (~req_i + 3'd1);

  // R2
  a_r2_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R3, R4
  a_r4_idle_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == 3'b000 && req_i != 3'b000) |=> (gnt_o == $past(low_req)));

  a_r5_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == 3'b000 && req_i == 3'b000) |=> (gnt_o == 3'b000));

  a_r6_grant_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & req_i) != 3'b000) |=> $stable(gnt_o));

  a_r7_release_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != 3'b000 && (gnt_o & req_i) == 3'b000) |=> (gnt_o == 3'b000));
endmodule

bind arb3_fixed_prio arb3_fixed_prio_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .gnt_o  (gnt_o)
);

// File: tb/test_arb3_fixed_prio.sv
module test_arb3_fixed_prio;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = 3'b000;
  logic [2:0] gnt;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arb3_fixed_prio i_arb3_fixed_prio (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .gnt_o  (gnt)
  );

  function automatic logic [2:0] lowest(input logic [2:0] r);
    return r & (~r + 3'd1);
  endfunction

  task automatic check(input string tag, input logic [2:0] exp);
    n_checks++;
    if (gnt !== exp) begin
      n_errors++;
      $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
    end
    if (!$onehot0(gnt)) begin
      n_errors++;
      $display("FAIL R2: gnt=%b expected at most one bit", gnt);
    end
  endtask

  task automatic step(input logic [2:0] r);
    @(negedge clk);
    req = r;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req   = 3'b000;
    #1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #3;
    check("R1 reset", 3'b000);
    @(negedge clk);
    rst_n = 1'b1;

    // Sweep: every state x every request pattern
    for (int st = 0; st < 4; st++) begin
      for (int r = 0; r < 8; r++) begin
        logic [2:0] exp;
        logic [2:0] held;
        do_reset();
        held = 3'b000;
        if (st > 0) begin
          held = 3'(1 << (st - 1));
          step(held);
          check("R3/R4 enter grant", held);
        end
        step(3'(r));
        if (st == 0) begin
          exp = lowest(3'(r));
          if (r == 0)          check("R5 idle stays", exp);
          else if (r[0])       check("R3 req1 wins", exp);
          else                 check("R4 lower priority pick", exp);
        end else if ((3'(r) & held) != 3'b000) begin
          check("R6 hold grant", held);
        end else begin
          check("R7 release to idle", 3'b000);
          step(3'(r));
          check("R7 pick after idle gap", lowest(3'(r)));
        end
      end
    end

    // R8: request changes between edges do not touch grants
    do_reset();
    step(3'b010);
    check("R8 setup", 3'b010);
    @(negedge clk);
    req = 3'b001;
    #1;
    check("R8 mid-cycle raise", 3'b010);
    req = 3'b000;
    #1;
    check("R8 mid-cycle drop", 3'b010);
    @(posedge clk);
    #2;
    check("R7 drop seen at edge", 3'b000);

    // R1: asynchronous reset clears held grant without an edge
    step(3'b100);
    check("R1 setup", 3'b100);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", 3'b000);
    @(posedge clk);
    #2;
    check("R1 held in reset", 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    req = 3'b000;
    step(3'b000);
    check("R1 idle after reset", 3'b000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule